// File: doc/BRIEF.md
# Gated Pulse-Width Capture Timer

This block times how long an external signal stays at its active level, and it can repeat the measurement. A counter is clocked by the system clock through a power-of-two prescaler. When gating is on, the counter stops while the synchronized input sits at a programmed level. A selectable input edge copies the counter into a capture register. The same edge can also reload the counter from a reload value, so that each captured number is one complete pulse length.

A single-shot mode arms the timer first. The measurement starts at the first of two events: a capture edge, or the gate opening. It ends at the next capture edge, which stores the result and raises an interrupt flag. After that the counter keeps running under the gate, but it takes no further captures. Software arms the timer again by dropping the run control and then setting it. The interrupt flag stays set until it is cleared. A capture made while the flag is still set also sets an overrun flag. A counter that wraps sets an overflow flag, so a pulse too long to measure can be detected.

Top module: `pw_capture_timer`

## Requirements
- R1: While reset is asserted and after it, the counter, the capture register and the irq, overrun and overflow flags are all zero.
- R2: The input passes through a two-flop synchronizer. A capture caused by an input change made between two clock edges is visible on the outputs after the third rising edge that follows the change.
- R3: While running, the counter advances at most once every 2^`div_i` clocks. The prescaler restarts from zero while run is low.
- R4: With `gate_en_i` high, the counter does not advance in any cycle where the synchronized input equals `gate_lvl_i`. The exceptions are a capture edge or a start event.
- R5: `edge_sel_i` chooses the capture edge: 00 none, 01 rising, 10 falling, 11 both. A capture loads the capture register with the counter value held just before that edge.
- R6: With `reload_en_i` high, a capture loads the counter with `reload_i`. With it low, the counter keeps counting through a capture.
- R7: With run and single-shot set, the timer waits without counting. It starts at the first capture edge or at the first cycle in which the gate goes from closed to open. A start loads the counter with `reload_i` (when reload is enabled), plus one if that cycle counts. The next capture edge stores the result and raises irq. After that the counter keeps counting under the gate, and further edges are ignored until run is dropped and set again.
- R8: With run set and single-shot clear, every capture edge performs a capture and raises irq.
- R9: irq stays set until `flag_clr_i` is pulsed. A new capture in the same cycle as the clear wins.
- R10: A capture made while irq is set, and not being cleared in that cycle, sets overrun. `flag_clr_i` clears overrun.
- R11: A counting step from all-ones loads `reload_i` and sets overflow. `flag_clr_i` clears overflow unless a wrap happens in the same cycle.
- R12: While run is low, the counter and the capture register hold, and no capture or irq occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous measured input |
| run_i | input | 1 | Run control |
| single_shot_i | input | 1 | Single-shot measurement mode |
| gate_en_i | input | 1 | Enable input-level gating |
| gate_lvl_i | input | 1 | Input level that blocks counting |
| reload_en_i | input | 1 | Reload counter on capture |
| edge_sel_i | input | 2 | Capture edge select (00 none, 01 rise, 10 fall, 11 both) |
| div_i | input | DIV_W | Prescaler exponent, divide by 2^div_i |
| reload_i | input | W | Reload value |
| flag_clr_i | input | 1 | Clear pulse for irq, overrun and overflow |
| count_o | output | W | Current counter value |
| capture_o | output | W | Captured value |
| irq_o | output | 1 | Capture interrupt flag |
| overrun_o | output | 1 | Capture made while irq was pending |
| overflow_o | output | 1 | Counter wrapped |

## Verification
The bench builds the timer with an 8-bit counter and a 2-bit prescaler exponent. With these values a wrap to the reload value, and the overflow flag, come within a few hundred cycles, and every divide ratio up to 8 can be reached. The bench runs a cycle model next to the design and drives measured pulses of known length under both gate levels. It covers both ways of starting a single-shot measurement, re-arming, every edge-select code, reload on and off, overrun and the freeze while stopped.

// File: rtl/pw_capture_timer.sv
module pw_capture_timer #(
  parameter int W     = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             run_i,
  input  logic             single_shot_i,
  input  logic             gate_en_i,
  input  logic             gate_lvl_i,
  input  logic             reload_en_i,
  input  logic [1:0]       edge_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [W-1:0]     reload_i,
  input  logic             flag_clr_i,
  output logic [W-1:0]     count_o,
  output logic [W-1:0]     capture_o,
  output logic             irq_o,
  output logic             overrun_o,
  output logic             overflow_o
);
  localparam int PW = (1 << DIV_W) - 1;

  typedef enum logic [1:0] {ARMED, MEAS, DONE} phase_t;

  phase_t        phase;
  logic [PW-1:0] pre;
  logic [PW-1:0] lim;
  logic          s1, s2, s3, gq;
  logic [W-1:0]  cnt, cap;
  logic          irq, ovr, ovf;

  logic          tick, rise, fall, cap_edge, gated, inc, ss, start, take, hold, ovf_set;
  logic [W-1:0]  base;
  logic [W:0]    stepped;

  function automatic logic [W:0] bump(input logic [W-1:0] v, input logic en,
                                      input logic [W-1:0] rl);
    if (!en)         return {1'b0, v};
    else if (&v)     return {1'b1, rl};
    else             return {1'b0, v + 1'b1};
  endfunction

  assign lim      = ~({PW{1'b1}} << div_i);
  assign tick     = pre >= lim;
  assign rise     = s2 & ~s3;
  assign fall     = ~s2 & s3;
  assign cap_edge = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);
  assign gated    = gate_en_i & (s2 == gate_lvl_i);
  assign inc      = run_i & tick & ~gated;
  assign ss       = run_i & single_shot_i;
  assign start    = ss & (phase == ARMED) & (cap_edge | (gq & ~gated));
  assign take     = run_i & cap_edge & (~single_shot_i | (phase == MEAS));
  assign hold     = ~run_i | (ss & (phase == ARMED) & ~start);
  assign base     = (start & reload_en_i) ? reload_i : cnt;
  assign stepped  = bump(base, inc, reload_i);
  assign ovf_set  = ~hold & ~(take & reload_en_i) & stepped[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      gq <= 1'b0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
      gq <= gated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre <= '0;
    else if (!run_i)    pre <= '0;
    else if (tick)      pre <= '0;
    else                pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (hold)                  cnt <= cnt;
    else if (take && reload_en_i)   cnt <= reload_i;
    else                            cnt <= stepped[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= ARMED;
    else if (!ss)      phase <= ARMED;
    else begin
      case (phase)
        ARMED:   if (start)    phase <= MEAS;
        MEAS:    if (cap_edge) phase <= DONE;
        default:               phase <= DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
      irq <= 1'b0;
      ovr <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (take) cap <= cnt;

      if (take)            irq <= 1'b1;
      else if (flag_clr_i) irq <= 1'b0;

      if (take && irq && !flag_clr_i) ovr <= 1'b1;
      else if (flag_clr_i)            ovr <= 1'b0;

      if (ovf_set)         ovf <= 1'b1;
      else if (flag_clr_i) ovf <= 1'b0;
    end
  end

  assign count_o    = cnt;
  assign capture_o  = cap;
  assign irq_o      = irq;
  assign overrun_o  = ovr;
  assign overflow_o = ovf;
endmodule

// File: rtl/pw_capture_timer_chk.sv
module pw_capture_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_i,
  input logic [W-1:0] reload_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] capture_o,
  input logic         irq_o,
  input logic         overrun_o,
  input logic         overflow_o,
  input logic         gated,
  input logic         cap_edge
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (count_o == '0 && capture_o == '0 && !irq_o && !overrun_o && !overflow_o));

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !cap_edge) |=> $stable(count_o));

  p_cap_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capture_o) |-> capture_o == $past(count_o));

  p_irq_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(run_i));

  p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(irq_o));

  p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> count_o == $past(reload_i));

  p_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(count_o) && $stable(capture_o)));
endmodule

bind pw_capture_timer pw_capture_timer_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_i      (run_i),
  .reload_i   (reload_i),
  .count_o    (count_o),
  .capture_o  (capture_o),
  .irq_o      (irq_o),
  .overrun_o  (overrun_o),
  .overflow_o (overflow_o),
  .gated      (gated),
  .cap_edge   (cap_edge)
);

// File: tb/test_pw_capture_timer.sv
`timescale 1ns/1ps
module test_pw_capture_timer;
  localparam int W = 8;
  localparam int DIV_W = 2;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic pin = 0, run = 0, ssh = 0, gen = 0, glvl = 0, rlen = 0, clr = 0;
  logic [1:0] esel = 0;
  logic [DIV_W-1:0] div = 0;
  logic [W-1:0] rld = 0;
  logic [W-1:0] count_o, capture_o;
  logic irq_o, overrun_o, overflow_o;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pw_capture_timer #(.W(W), .DIV_W(DIV_W)) i_pw_capture_timer (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .run_i(run), .single_shot_i(ssh),
    .gate_en_i(gen), .gate_lvl_i(glvl), .reload_en_i(rlen), .edge_sel_i(esel),
    .div_i(div), .reload_i(rld), .flag_clr_i(clr), .count_o(count_o),
    .capture_o(capture_o), .irq_o(irq_o), .overrun_o(overrun_o), .overflow_o(overflow_o));

  // behavioural reference: phase 0 waiting, 1 measuring, 2 finished
  int m_q[$];
  int m_last, m_pre, m_cnt, m_cap, m_phase, m_gq, m_irq, m_ovr, m_ovf;

  always @(posedge clk) begin
    int lim, cur, edg, gtd, inc, start, take, hold, base, nxt, wr;
    if (!rst_n) begin
      m_q = '{0, 0}; m_last = 0; m_pre = 0; m_cnt = 0; m_cap = 0;
      m_phase = 0; m_gq = 0; m_irq = 0; m_ovr = 0; m_ovf = 0;
    end else begin
      cur = m_q[1];
      lim = (1 << div) - 1;
      edg = (esel[0] && cur == 1 && m_last == 0) || (esel[1] && cur == 0 && m_last == 1);
      gtd = gen && (cur == glvl);
      inc = run && (m_pre >= lim) && !gtd;
      start = run && ssh && m_phase == 0 && (edg || (m_gq && !gtd));
      take = run && edg && (!ssh || m_phase == 1);
      hold = !run || (ssh && m_phase == 0 && !start);
      base = (start && rlen) ? rld : m_cnt;
      wr = inc && base == MAXV;
      nxt = !inc ? base : (wr ? rld : base + 1);
      if (take) begin
        if (m_irq && !clr) m_ovr = 1; else if (clr) m_ovr = 0;
        m_irq = 1;
        m_cap = m_cnt;
      end else if (clr) begin
        m_irq = 0; m_ovr = 0;
      end
      if (!hold && !(take && rlen) && wr) m_ovf = 1; else if (clr) m_ovf = 0;
      if (!hold) m_cnt = (take && rlen) ? rld : nxt;
      if (!(run && ssh)) m_phase = 0;
      else if (m_phase == 0 && start) m_phase = 1;
      else if (m_phase == 1 && edg) m_phase = 2;
      m_pre = (!run || m_pre >= lim) ? 0 : m_pre + 1;
      m_gq = gtd;
      m_last = cur;
      m_q = '{int'(pin), m_q[0]};
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    cmp("R3 count", count_o, m_cnt);
    cmp("R5 capture", capture_o, m_cap);
    cmp("R9 irq", irq_o, m_irq);
    cmp("R10 overrun", overrun_o, m_ovr);
    cmp("R11 overflow", overflow_o, m_ovf);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pin = 1; wait_n(hi); pin = 0; wait_n(lo);
  endtask

  task automatic clear_flags();
    clr = 1; wait_n(1); clr = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    int rc, rp;
    wait_n(4);
    cmp("R1 count", count_o, 0); cmp("R1 capture", capture_o, 0);
    cmp("R1 flags", {irq_o, overrun_o, overflow_o}, 0);
    rst_n = 1;

    // R2 latency, continuous rising-edge capture
    run = 1; esel = 2'b01; rlen = 1; rld = 0; wait_n(5);
    pin = 1;
    wait_n(1); cmp("R2 irq after 1", irq_o, 0);
    wait_n(1); cmp("R2 irq after 2", irq_o, 0);
    wait_n(1); cmp("R2 irq after 3", irq_o, 1);
    pin = 0; wait_n(4); clear_flags();

    // R7 single shot, start by gate removal
    run = 0; wait_n(2);
    ssh = 1; gen = 1; glvl = 0; rld = 5; rlen = 1; esel = 2'b10; run = 1;
    wait_n(5);
    pulse(20, 6);
    cmp("R7 width 20", capture_o, 25); cmp("R7 irq", irq_o, 1);
    pulse(7, 6);
    cmp("R7 ignored edge", capture_o, 25); cmp("R7 counts after end", count_o, 12);

    // R7 re-arm with pin high, start by falling edge
    clear_flags(); pin = 1; wait_n(4); run = 0; wait_n(2); run = 1; wait_n(3);
    pin = 0; wait_n(5);
    pulse(13, 6);
    cmp("R7 width 13 edge start", capture_o, 18);

    // R3 divide by 4
    clear_flags(); run = 0; wait_n(2); div = 2; run = 1; wait_n(5);
    pulse(40, 8);
    cmp("R3 width 40 div4", capture_o, 15);

    // R4 gate level 1
    run = 0; wait_n(2); ssh = 0; glvl = 1; esel = 2'b00; div = 0; pin = 1; run = 1;
    wait_n(3); rc = count_o; wait_n(10);
    cmp("R4 gated hold", count_o, rc);
    pin = 0; wait_n(12);
    cmp("R4 ungated count", count_o, rc + 10);

    // R11 overflow wrap
    gen = 0; rld = 8'hF0; clear_flags(); wait_n(300);
    cmp("R11 overflow set", overflow_o, 1);
    cmp("R11 wrap range", count_o >= 8'hF0, 1);

    // R6 reload on and off
    rld = 0; rlen = 0; esel = 2'b01; wait_n(2);
    pin = 1; wait_n(3);
    cmp("R6 count continues", (count_o - capture_o) & MAXV, 1);
    pin = 0; wait_n(4); rlen = 1;
    pin = 1; wait_n(3);
    cmp("R6 reload on capture", count_o, 0);
    pin = 0; wait_n(4);

    // R8 R9 R10 repeated captures
    rlen = 0; clear_flags(); wait_n(2);
    pulse(3, 5); pulse(3, 6);
    cmp("R8 irq", irq_o, 1); cmp("R10 overrun", overrun_o, 1);
    clear_flags();
    cmp("R9 irq cleared", irq_o, 0); cmp("R10 overrun cleared", overrun_o, 0);

    // R5 edge select none and both
    esel = 2'b00; rc = capture_o; pulse(4, 6);
    cmp("R5 none capture", capture_o, rc); cmp("R5 none irq", irq_o, 0);
    esel = 2'b11; pulse(4, 6);
    cmp("R5 both irq", irq_o, 1); cmp("R5 both overrun", overrun_o, 1);

    // R12 stopped
    run = 0; wait_n(1); rc = count_o; rp = capture_o; clear_flags();
    pulse(4, 5); pulse(6, 5);
    cmp("R12 count held", count_o, rc); cmp("R12 capture held", capture_o, rp);
    cmp("R12 no irq", irq_o, 0);

    wait_n(3);
    finish_run();
  end
endmodule